// File: doc/BRIEF.md
# Seven-Level In-Phase Multicarrier PWM Gate Generator

This block drives the twelve gate signals of a seven-level inverter built from three series H-bridges. A single phase counter produces one triangle of amplitude H, where H is the half-period set on `period_i` in clock cycles. Six in-phase copies of that triangle are stacked so that together they span the band from -3H to +3H. Each copy is compared against a signed reference sample.

Three comparators handle the positive half of the output. The other three handle the negative half. Bridge b takes its positive decision from the band b steps above zero and its negative decision from the mirrored band below zero. Each bridge leg is driven with complementary upper and lower gates, and every gate comes from a register.

The reference has to be pre-scaled so that ±3H represents full modulation. The carrier-to-reference frequency ratio follows from the clock rate, `period_i` and the rate at which the reference is updated. For example, a carrier twenty-one times faster than the reference gives twenty-one pulses per reference cycle.

Top module: `ipd_pwm_gen`

## Requirements
- R1: While `rst_ni` is low, all twelve gate outputs are 0 and the phase counter is held at 0. The first cycle after release uses counter value 0.
- R2: The phase counter steps by one each clock from 0 to 2H-1 and then returns to 0. The triangle equals the count up to H, equals 2H minus the count above H, and peaks at H.
- R3: A `period_i` value of 0 is treated as H = 1.
- R4: Carrier k, for k = 0 to 5, equals (k-3)·H plus the triangle. All six carriers share the same amplitude, frequency and phase.
- R5: Comparator k is 1 when the signed reference is greater than or equal to carrier k, so a tie gives 1. Any comparator whose carrier lies above the reference is 0.
- R6: Bridge b (0 to 2) uses positive comparator 3+b and negative comparator 2-b. The gate bits are assigned as follows:
  - bit 4b is leg A upper, equal to the positive comparator;
  - bit 4b+1 is leg A lower, its inverse;
  - bit 4b+2 is leg B upper, equal to the inverse of the negative comparator;
  - bit 4b+3 is leg B lower, equal to the negative comparator.
- R7: The gate outputs are registered. The value on `gate_o` after a clock edge reflects the counter value and `ref_i` that were present before that edge.
- R8: Outside reset, the two gates of every leg are always complementary.
- R9: No bridge ever has both leg A upper and leg B upper on at the same time.
- R10: A reference at or above +3H turns all three leg A upper gates on. A reference below -3H turns all three leg B upper gates on.
- R11: If `period_i` shrinks so that the current count is at or past the new 2H-1, the counter returns to 0 on the next clock. Meanwhile, a count at or past 2H gives a triangle of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | HALF_W | Carrier half-period H in clocks |
| ref_i | input | REF_W | Signed reference sample, full scale ±3H |
| gate_o | output | 12 | Gate signals, four per bridge |

## Verification
Two situations can fall in the same cycle. The first is the counter wrap happening together with a period change. The bench provokes this by shrinking `period_i` while the count is already beyond the new end, and then checks that the following gate pattern uses a count of 0. The second is the reference landing exactly on a band edge at a carrier peak or valley, where the greater-or-equal tie rule decides two neighbouring bands at once. This is provoked by holding the reference at 0 and at multiples of H while the triangle passes through 0 and H, and it is judged against a behavioural model that compares the outputs on every clock.

// File: rtl/ipd_pwm_pkg.sv
package ipd_pwm_pkg;
  localparam int NUM_CARR    = 6;
  localparam int NUM_BRIDGE  = NUM_CARR / 2;
  localparam int GATES_PER_B = 4;
  localparam int NUM_GATES   = NUM_BRIDGE * GATES_PER_B;

  // gate slot within one bridge
  typedef enum int {
    SLOT_A_HI = 0,
    SLOT_A_LO = 1,
    SLOT_B_HI = 2,
    SLOT_B_LO = 3
  } gate_slot_e;

  function automatic int cmp_width(input int half_w, input int ref_w);
    int w;
    w = (ref_w > half_w + 3) ? ref_w : half_w + 3;
    return w + 1;
  endfunction
endpackage

// File: rtl/ipd_pwm_phase.sv
module ipd_pwm_phase #(
  parameter int HALF_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] period_i,
  output logic [HALF_W:0]   half_o,
  output logic [HALF_W:0]   tri_o
);
  localparam int CNT_W = HALF_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half, full;
  logic             wrap;

  assign half = (period_i == '0) ? CNT_W'(1) : CNT_W'(period_i);
  assign full = half << 1;
  assign wrap = (cnt_q >= full - CNT_W'(1));
  assign cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    if (cnt_q <= half)     tri_o = cnt_q;
    else if (cnt_q < full) tri_o = full - cnt_q;
    else                   tri_o = '0;
  end

  assign half_o = half;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_TRI_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_o <= half_o); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= full - CNT_W'(1)) |=> (cnt_q == '0)); // R11
  AST_HALF_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o != '0); // R3
endmodule

// File: rtl/ipd_pwm_carriers.sv
module ipd_pwm_carriers
  import ipd_pwm_pkg::*;
#(
  parameter int HALF_W = 10,
  parameter int REF_W  = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [HALF_W:0]         half_i,
  input  logic [HALF_W:0]         tri_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [NUM_CARR-1:0]     cmp_o
);
  localparam int CMP_W = cmp_width(HALF_W, REF_W);

  logic signed [CMP_W-1:0] h_s, t_s, r_s;

  assign h_s = signed'(CMP_W'(half_i));
  assign t_s = signed'(CMP_W'(tri_i));
  assign r_s = CMP_W'(ref_i);

  for (genvar k = 0; k < NUM_CARR; k++) begin : g_band
    localparam int OFS = k - NUM_CARR / 2;
    logic signed [CMP_W-1:0] car;
    assign car      = signed'(CMP_W'(OFS)) * h_s + t_s;
    assign cmp_o[k] = (r_s >= car);

    if (k > 0) begin : g_mono
      AST_CMP_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_o[k] |-> cmp_o[k-1]); // R5
    end
  end
endmodule

// File: rtl/ipd_pwm_gates.sv
module ipd_pwm_gates
  import ipd_pwm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CARR-1:0]  cmp_i,
  output logic [NUM_GATES-1:0] gate_o
);
  localparam int MID = NUM_CARR / 2;

  logic [NUM_GATES-1:0] gate_d, gate_q;

  for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_bridge
    logic pos_c, neg_c;
    assign pos_c = cmp_i[MID + b];
    assign neg_c = cmp_i[MID - 1 - b];

    assign gate_d[GATES_PER_B*b + SLOT_A_HI] = pos_c;
    assign gate_d[GATES_PER_B*b + SLOT_A_LO] = ~pos_c;
    assign gate_d[GATES_PER_B*b + SLOT_B_HI] = ~neg_c;
    assign gate_d[GATES_PER_B*b + SLOT_B_LO] = neg_c;

    AST_LEG_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (gate_q[GATES_PER_B*b + SLOT_A_HI] != gate_q[GATES_PER_B*b + SLOT_A_LO])
                     && (gate_q[GATES_PER_B*b + SLOT_B_HI] != gate_q[GATES_PER_B*b + SLOT_B_LO])); // R8
    AST_NO_BIPOLAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_q[GATES_PER_B*b + SLOT_A_HI] && gate_q[GATES_PER_B*b + SLOT_B_HI])); // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_d;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_LOW: assert (gate_q == '0); // R1
    end
  end

  AST_GATE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (gate_q[GATES_PER_B*0 + SLOT_A_HI] == $past(cmp_i[MID]))); // R7

  assign gate_o = gate_q;
endmodule

// File: rtl/ipd_pwm_gen.sv
module ipd_pwm_gen
  import ipd_pwm_pkg::*;
#(
  parameter int HALF_W = 10,
  parameter int REF_W  = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [HALF_W-1:0]       period_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [NUM_GATES-1:0]    gate_o
);
  logic [HALF_W:0]       half, tri_v;
  logic [NUM_CARR-1:0]   cmp;

  ipd_pwm_phase #(.HALF_W(HALF_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .half_o   (half),
    .tri_o    (tri_v)
  );

  ipd_pwm_carriers #(.HALF_W(HALF_W), .REF_W(REF_W)) u_carr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (half),
    .tri_i  (tri_v),
    .ref_i  (ref_i),
    .cmp_o  (cmp)
  );

  ipd_pwm_gates u_gates (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp),
    .gate_o (gate_o)
  );
endmodule

// File: tb/ipd_pwm_gen_tb.sv
module ipd_pwm_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W = 10;
  localparam int REF_W  = 14;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b1;
  logic [HALF_W-1:0]       period_i = '0;
  logic signed [REF_W-1:0] ref_i = '0;
  logic [11:0]             gate_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cnt_m = 0;
  bit done  = 1'b0;

  ipd_pwm_gen #(.HALF_W(HALF_W), .REF_W(REF_W)) u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .ref_i    (ref_i),
    .gate_o   (gate_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [11:0] model(input int cnt, input int rv, input int pv);
    int h, tv, car;
    logic [5:0] c;
    logic [11:0] g;
    h = (pv == 0) ? 1 : pv;                                 // R3
    if (cnt <= h)         tv = cnt;                         // R2
    else if (cnt < 2 * h) tv = 2 * h - cnt;
    else                  tv = 0;                           // R11
    for (int k = 0; k < 6; k++) begin
      car  = (k - 3) * h + tv;                              // R4
      c[k] = (rv >= car);                                   // R5
    end
    for (int b = 0; b < 3; b++) begin                       // R6
      g[4*b]   = c[3+b];
      g[4*b+1] = ~c[3+b];
      g[4*b+2] = ~c[2-b];
      g[4*b+3] = c[2-b];
    end
    return g;
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gate_o=%03h expected %03h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs applied at negedge, result sampled at the following negedge (R7)
  task automatic step(input int rv, input int pv, input string tag);
    logic [11:0] exp;
    int h;
    ref_i    = REF_W'(rv);
    period_i = HALF_W'(pv);
    exp = model(cnt_m, rv, pv);
    h = (pv == 0) ? 1 : pv;
    cnt_m = (cnt_m >= 2 * h - 1) ? 0 : cnt_m + 1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, gate_o, exp);
    for (int b = 0; b < 3; b++) begin
      check("R8", {10'd0, gate_o[4*b] ^ gate_o[4*b+1], gate_o[4*b+2] ^ gate_o[4*b+3]}, 12'b11);
      check("R9", {11'd0, gate_o[4*b] & gate_o[4*b+2]}, 12'd0);
    end
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    period_i = HALF_W'(4);
    ref_i    = REF_W'(5);
    repeat (3) @(negedge clk_i);
    check("R1", gate_o, 12'h000);
    rst_ni = 1'b1;
    cnt_m  = 0;

    // R1: first cycle after release uses count 0; ties at band edges (R5)
    for (int i = 0; i < 24; i++) step(0, 4, "R5");
    for (int i = 0; i < 16; i++) step(4, 4, "R5");
    for (int i = 0; i < 16; i++) step(-8, 4, "R5");

    // R4/R6: ramp across all six bands
    for (int v = -14; v <= 14; v++) step(v, 4, "R6");

    // R10: saturation both ways
    for (int i = 0; i < 10; i++) step(12, 4, "R10");
    for (int i = 0; i < 10; i++) step(300, 4, "R10");
    for (int i = 0; i < 10; i++) step(-13, 4, "R10");
    for (int i = 0; i < 10; i++) step(-300, 4, "R10");

    // R3: zero period
    for (int i = 0; i < 12; i++) step(i % 2 == 0 ? 1 : -2, 0, "R3");

    // R11: shrink period while count is beyond the new end
    while (cnt_m != 0) step(3, 8, "R2");
    for (int i = 0; i < 10; i++) step(5, 8, "R2");
    for (int i = 0; i < 14; i++) step(-4, 3, "R11");

    // R2/R7: pseudo-random reference
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(int'(lf % 16'd33) - 16, 5, "R7");
      end
    end

    // R1: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", gate_o, 12'h000);
    rst_ni = 1'b1;
    cnt_m  = 0;
    for (int i = 0; i < 12; i++) step(2, 6, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule